// File: doc/BRIEF.md
# Masked Address Range Matcher

This block tells an event counter whether the address of a retiring instruction, or of a data access, lies inside a programmed region of memory. A region is not stored as a start and an end address. It is the union of up to four pairs. Each pair holds a base address and a compare mask, and so covers one naturally aligned region whose size is a power of two. Software splits an arbitrary range into such pairs. The matched region can therefore be slightly larger than the range that was requested. Each pair also carries a privilege-enable field, so that a pair only counts while the processor runs at a level enabled in that field.

The block has two independent channels. The code channel and the data channel each have their own set of four pairs, and both match in the same cycle. The code channel also has a checkpoint mode. In this mode only its first pair is used, and it is narrowed to a single 16-byte bundle. A hit in this mode credits three instructions, one for each slot of the bundle, so the counter can be divided by three to count how often that bundle was executed. Matching depends only on the address. A routine called from inside the region but located outside it does not match.

Top module: `addr_range_match`

## Requirements
- R1: A pair matches when the access address and the pair's base are equal on every bit position 0..55 where the mask field (bits 55:0 of the mask register) holds a 1. Address bits 63:56 are never compared.
- R2: A channel's match is the OR of its enabled pairs.
- R3: A pair matches only if bit `curPl` of its privilege field (bits 59:56 of the mask register) is 1. Value 0x8 enables level 3 (user) only, and 0x1 enables level 0 (kernel) only. Bits 63:60 of the mask register are ignored.
- R4: A pair whose privilege field is zero never matches, whatever its base and mask.
- R5: Register writes use `cfgSel`. Bit 3 selects the set (0 code, 1 data), bits 2:1 select the pair, and bit 0 selects the register (0 base, 1 mask). The code and data channels match at the same time and do not affect each other.
- R6: When `chkMode` is 1, the code channel uses pair 0 only. It compares address bits 55:4 with the base and ignores the stored mask field. Pair 0's privilege field still applies, pairs 1..3 are ignored, and the data channel is unaffected.
- R7: `iIncr` is 3 on a code hit in checkpoint mode, 1 on a code hit in normal mode, and 0 when there is no code hit.
- R8: `iHit` and `dHit` are registered. Each reflects the strobe and address sampled at the previous rising edge, and is 0 if that strobe was low.
- R9: Reset clears both hit outputs and `iIncr`, and disables every pair.
- R10: A register written at one edge affects only accesses sampled at later edges. An access sampled at the same edge still sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 4 | Register select {set, pair, base/mask} |
| cfgData | input | 64 | Register write data |
| chkMode | input | 1 | Code channel checkpoint (single bundle) mode |
| curPl | input | 2 | Current privilege level |
| iValid | input | 1 | Code address strobe |
| iAddr | input | 64 | Code address |
| dValid | input | 1 | Data address strobe |
| dAddr | input | 64 | Data address |
| iHit | output | 1 | Code address was in range |
| dHit | output | 1 | Data address was in range |
| iIncr | output | 2 | Instructions credited for the code hit |

## Verification
The hardest case to reach is a write that lands on the same edge as an access the write would change. The bench keeps a strobe held while it enables a pair whose mask is zero and which would match every address. It then expects a miss in the first cycle and a hit in the next. It uses the same overlap to disable the pair again. Pairs left disabled with an all-zero mask are also present throughout the table of vectors. Any leak of the zero privilege field would then show up as a stray hit.

// File: rtl/arm_pkg.sv
package arm_pkg;
  localparam int ADDR_W      = 64;
  localparam int NUM_PAIRS   = 4;
  localparam int NUM_CHAN    = 2;   // 0 = code, 1 = data
  localparam int CMP_W       = 56;  // compared address bits
  localparam int PL_W        = 4;   // privilege-enable field width
  localparam int PL_LSB      = 56;  // field position in mask register
  localparam int BUNDLE_BITS = 4;   // 16-byte bundle
  localparam int SLOTS       = 3;   // instructions per bundle
  localparam int PAIR_W      = $clog2(NUM_PAIRS);
  localparam int SEL_W       = PAIR_W + 2;

  typedef struct packed {
    logic [NUM_CHAN-1:0][NUM_PAIRS-1:0] wrBase;
    logic [NUM_CHAN-1:0][NUM_PAIRS-1:0] wrMask;
    logic [NUM_CHAN-1:0]                sample;
    logic                               ckpt;
  } ctrl_t;
endpackage

// File: rtl/arm_ctrl.sv
module arm_ctrl
  import arm_pkg::*;
(
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             chkMode,
  input  logic             iValid,
  input  logic             dValid,
  output ctrl_t            ctrl
);
  logic             selChan;
  logic [PAIR_W-1:0] selPair;
  logic             selMask;

  assign selChan = cfgSel[SEL_W-1];
  assign selPair = cfgSel[PAIR_W:1];
  assign selMask = cfgSel[0];

  always_comb begin
    ctrl.wrBase = '0;
    ctrl.wrMask = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (cfgWe && (int'(selChan) == c) && (int'(selPair) == p)) begin
          ctrl.wrBase[c][p] = !selMask;
          ctrl.wrMask[c][p] = selMask;
        end
      end
    end
    ctrl.sample = {dValid, iValid};
    ctrl.ckpt   = chkMode;
  end
endmodule

// File: rtl/arm_datapath.sv
module arm_datapath
  import arm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic [1:0]        curPl,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic [ADDR_W-1:0] dAddr,
  output logic              iHit,
  output logic              dHit,
  output logic [1:0]        iIncr
);
  localparam logic [CMP_W-1:0] BUNDLE_MASK =
    {{(CMP_W-BUNDLE_BITS){1'b1}}, {BUNDLE_BITS{1'b0}}};

  logic [CMP_W-1:0] baseR [NUM_CHAN][NUM_PAIRS];
  logic [CMP_W-1:0] maskR [NUM_CHAN][NUM_PAIRS];
  logic [PL_W-1:0]  plmR  [NUM_CHAN][NUM_PAIRS];
  logic [CMP_W-1:0] chanAddr [NUM_CHAN];
  logic [NUM_CHAN-1:0][NUM_PAIRS-1:0] pairHit;
  logic [NUM_CHAN-1:0] chanHit;
  logic unusedBits;

  assign chanAddr[0] = iAddr[CMP_W-1:0];
  assign chanAddr[1] = dAddr[CMP_W-1:0];
  assign unusedBits  = ^{cfgData[ADDR_W-1:PL_LSB+PL_W],
                         iAddr[ADDR_W-1:CMP_W], dAddr[ADDR_W-1:CMP_W]};

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [CMP_W-1:0] effMask;
      logic             pairEn;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          baseR[c][p] <= '0;
          maskR[c][p] <= '0;
          plmR[c][p]  <= '0;
        end else begin
          if (ctrl.wrBase[c][p]) baseR[c][p] <= cfgData[CMP_W-1:0];
          if (ctrl.wrMask[c][p]) begin
            maskR[c][p] <= cfgData[CMP_W-1:0];
            plmR[c][p]  <= cfgData[PL_LSB +: PL_W];
          end
        end
      end

      if (c == 0) begin : g_code
        assign effMask = ctrl.ckpt ? ((p == 0) ? BUNDLE_MASK : maskR[c][p])
                                   : maskR[c][p];
        assign pairEn  = plmR[c][p][curPl] && !(ctrl.ckpt && (p != 0));
      end else begin : g_data
        assign effMask = maskR[c][p];
        assign pairEn  = plmR[c][p][curPl];
      end

      assign pairHit[c][p] = pairEn &&
        (((chanAddr[c] ^ baseR[c][p]) & effMask) == '0);
    end
    assign chanHit[c] = |pairHit[c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iHit  <= 1'b0;
      dHit  <= 1'b0;
      iIncr <= '0;
    end else begin
      iHit  <= ctrl.sample[0] && chanHit[0];
      dHit  <= ctrl.sample[1] && chanHit[1];
      if (ctrl.sample[0] && chanHit[0])
        iIncr <= ctrl.ckpt ? 2'(SLOTS) : 2'd1;
      else
        iIncr <= '0;
    end
  end
endmodule

// File: rtl/addr_range_match.sv
module addr_range_match
  import arm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              chkMode,
  input  logic [1:0]        curPl,
  input  logic              iValid,
  input  logic [ADDR_W-1:0] iAddr,
  input  logic              dValid,
  input  logic [ADDR_W-1:0] dAddr,
  output logic              iHit,
  output logic              dHit,
  output logic [1:0]        iIncr
);
  ctrl_t ctrl;

  arm_ctrl i_ctrl (
    .cfgWe(cfgWe), .cfgSel(cfgSel), .chkMode(chkMode),
    .iValid(iValid), .dValid(dValid), .ctrl(ctrl)
  );

  arm_datapath i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .cfgData(cfgData),
    .curPl(curPl), .iAddr(iAddr), .dAddr(dAddr),
    .iHit(iHit), .dHit(dHit), .iIncr(iIncr)
  );
endmodule

// File: rtl/arm_checker.sv
module arm_checker (
  input logic       clk,
  input logic       rstN,
  input logic       chkMode,
  input logic       iValid,
  input logic       dValid,
  input logic       iHit,
  input logic       dHit,
  input logic [1:0] iIncr
);
  p_code_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !iValid |=> !iHit);

  p_data_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !dValid |=> !dHit);

  p_incr_needs_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
    !iHit |-> (iIncr == 2'd0));

  p_incr_value_r7: assert property (@(posedge clk) disable iff (!rstN)
    iHit |-> (iIncr == ($past(chkMode) ? 2'd3 : 2'd1)));

  p_hit_after_strobe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (iHit || dHit) |-> $past(iValid || dValid));
endmodule

bind addr_range_match arm_checker i_arm_checker (
  .clk(clk), .rstN(rstN), .chkMode(chkMode), .iValid(iValid),
  .dValid(dValid), .iHit(iHit), .dHit(dHit), .iIncr(iIncr)
);

// File: tb/test_addr_range_match.sv
`timescale 1ns/1ps
module test_addr_range_match;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [63:0] cfgData = '0;
  logic        chkMode = 1'b0;
  logic [1:0]  curPl = 2'd3;
  logic        iValid = 1'b0;
  logic [63:0] iAddr = '0;
  logic        dValid = 1'b0;
  logic [63:0] dAddr = '0;
  logic        iHit, dHit;
  logic [1:0]  iIncr;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  addr_range_match i_addr_range_match (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .chkMode(chkMode), .curPl(curPl),
    .iValid(iValid), .iAddr(iAddr), .dValid(dValid), .dAddr(dAddr),
    .iHit(iHit), .dHit(dHit), .iIncr(iIncr)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        chk;
    logic [1:0]  pl;
    logic        iv;
    logic [63:0] ia;
    logic        dv;
    logic [63:0] da;
    logic        ei;
    logic        ed;
    logic [1:0]  einc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{8'd1, 1'b0, 2'd3, 1'b1, 64'h1000, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1},  // R1 low edge
    '{8'd1, 1'b0, 2'd3, 1'b1, 64'h13ff, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1},  // R1 high edge
    '{8'd2, 1'b0, 2'd3, 1'b1, 64'h1450, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1},  // R2 second pair
    '{8'd3, 1'b0, 2'd3, 1'b1, 64'h1590, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},  // R3 kernel-only pair at user
    '{8'd3, 1'b0, 2'd0, 1'b1, 64'h1590, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1},  // R3 kernel level
    '{8'd3, 1'b0, 2'd0, 1'b1, 64'h1000, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},  // R3 user-only pair at kernel
    '{8'd4, 1'b0, 2'd3, 1'b1, 64'h1600, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},  // R4 past end, pair3 off
    '{8'd1, 1'b0, 2'd3, 1'b1, 64'hff00_0000_0000_1000, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1}, // R1 top byte
    '{8'd1, 1'b0, 2'd3, 1'b1, 64'h0080_0000_0000_1000, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0}, // R1 bit 55
    '{8'd5, 1'b0, 2'd3, 1'b0, 64'h1000, 1'b1, 64'h6000_0000_0002_5555, 1'b0, 1'b1, 2'd0}, // R5 R8
    '{8'd5, 1'b0, 2'd3, 1'b1, 64'h1450, 1'b1, 64'h6000_0000_0001_ffff, 1'b1, 1'b0, 2'd1}, // R5
    '{8'd5, 1'b0, 2'd1, 1'b1, 64'h1000, 1'b1, 64'h6000_0000_0002_ffff, 1'b0, 1'b1, 2'd0}, // R5 R3
    '{8'd6, 1'b1, 2'd3, 1'b1, 64'h100f, 1'b1, 64'h6000_0000_0002_0010, 1'b1, 1'b1, 2'd3}, // R6 R7
    '{8'd6, 1'b1, 2'd3, 1'b1, 64'h1010, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},  // R6 next bundle
    '{8'd6, 1'b1, 2'd3, 1'b1, 64'h1450, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},  // R6 pair1 ignored
    '{8'd6, 1'b1, 2'd0, 1'b1, 64'h1008, 1'b0, 64'h0, 1'b0, 1'b0, 2'd0},  // R6 privilege still gates
    '{8'd7, 1'b0, 2'd3, 1'b1, 64'h1010, 1'b0, 64'h0, 1'b1, 1'b0, 2'd1}   // R7 normal credit
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] maskWord(input logic [3:0] plm, input logic [55:0] m);
    return {4'h0, plm, m};
  endfunction

  task automatic writeReg(input logic [3:0] sel, input logic [63:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs low in reset
    check("R9 iHit in reset", iHit, 0);
    check("R9 dHit in reset", dHit, 0);
    check("R9 iIncr in reset", iIncr, 0);
    rstN = 1'b1;
    // R4 R9: every pair disabled after reset, strobe any address
    iValid = 1'b1; iAddr = 64'h0; dValid = 1'b1; dAddr = 64'h0;
    @(negedge clk);
    check("R4 code after reset", iHit, 0);
    check("R9 data after reset", dHit, 0);
    iValid = 1'b0; dValid = 1'b0;

    // code set: sel = {0, pair, isMask}
    writeReg(4'b0000, 64'h1000);
    writeReg(4'b0001, maskWord(4'h8, 56'hff_ffff_ffff_fc00));
    writeReg(4'b0010, 64'h1400);
    writeReg(4'b0011, maskWord(4'h8, 56'hff_ffff_ffff_ff00));
    writeReg(4'b0100, 64'h1500);
    writeReg(4'b0101, {4'hf, 4'h1, 56'hff_ffff_ffff_ff00}); // R3 upper nibble ignored
    // data set pair 0
    writeReg(4'b1000, 64'h6000_0000_0002_0000);
    writeReg(4'b1001, maskWord(4'hf, 56'hff_ffff_ffff_0000));

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      chkMode = VEC[k].chk; curPl = VEC[k].pl;
      iValid = VEC[k].iv; iAddr = VEC[k].ia;
      dValid = VEC[k].dv; dAddr = VEC[k].da;
      @(negedge clk);
      check($sformatf("R%0d vec%0d iHit", VEC[k].req, k), iHit, VEC[k].ei);
      check($sformatf("R%0d vec%0d dHit", VEC[k].req, k), dHit, VEC[k].ed);
      check($sformatf("R%0d vec%0d iIncr", VEC[k].req, k), iIncr, VEC[k].einc);
    end

    // R10: enable catch-all pair3 on the same edge as an access
    @(negedge clk);
    chkMode = 1'b0; curPl = 2'd3; dValid = 1'b0;
    iValid = 1'b1; iAddr = 64'h9000;
    cfgWe = 1'b1; cfgSel = 4'b0111; cfgData = maskWord(4'h8, 56'h0);
    @(negedge clk);
    cfgWe = 1'b0;
    check("R10 old value on write edge", iHit, 0);
    @(negedge clk);
    check("R10 new value next edge", iHit, 1);
    // R4: clear privilege field while strobe held
    cfgWe = 1'b1; cfgSel = 4'b0111; cfgData = maskWord(4'h0, 56'h0);
    @(negedge clk);
    cfgWe = 1'b0;
    check("R10 still old on write edge", iHit, 1);
    @(negedge clk);
    check("R4 zero privilege disables", iHit, 0);

    // R8: strobe dropped gives low output next cycle
    iValid = 1'b0; iAddr = 64'h1000;
    @(negedge clk);
    check("R8 no strobe", iHit, 0);
    check("R7 no strobe credit", iIncr, 0);

    // R9: reset mid-run disables programmed pairs
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    iValid = 1'b1; iAddr = 64'h1000; dValid = 1'b1; dAddr = 64'h6000_0000_0002_0000;
    @(negedge clk);
    check("R9 code pairs cleared", iHit, 0);
    check("R9 data pairs cleared", dHit, 0);
    iValid = 1'b0; dValid = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule